// File: doc/BRIEF.md
# Secure Multi-CPU Interrupt Router

This block gathers 32 interrupt request lines and holds each one as pending until software clears it. It steers every pending source to any of four processors. For each processor the source gets a priority level, and it is delivered on that processor's normal interrupt line or on its fast interrupt line. Each processor also receives a two-bit code giving the best priority among the sources that currently reach it.

Software programs the block over a simple synchronous register bus. Every bus transaction carries a secure attribute. A source is treated as secured once any of its per-processor trust bits is set. Non-secure masters do not see secured sources in the pending register, and cannot clear them. Routing nibbles whose trust bit is set cannot be changed from the non-secure side. While the control lock is set, the clock-gate and soft-reset bits are likewise closed to non-secure writes.

A write that is not permitted is dropped without any error indication. The block also provides a soft reset that wipes pending and routing state over two cycles, and a clock-gate mode. In clock-gate mode no new requests are latched and only non-maskable sources reach the processors.

Top module: `sirq_router`

## Requirements
- R1: After synchronous reset, every register reads as 0 and all irq_o, fiq_o and prio_o bits are 0.
- R2: A source that is high at a rising clock edge (with gate clear) sets its bit n of the pending register (address 0x10). The bit stays set until it is cleared. Read data appears on bus_rdata one cycle after the read is presented.
- R3: Writing 1s to the write-only clear register (address 0x14) clears the matching pending bits in the next cycle.
- R4: The routing register of source n sits at 0x20 + 16*n and is 16 bits wide. Processor k owns bits [4k+3:4k]. Within that nibble, bits [3:2] are the priority (0 masked, 1 low, 2 high, 3 non-maskable), bit 1 is the type (0 normal, 1 fast) and bit 0 is the trust bit.
- R5: irq_o[k] (fiq_o[k]) is 1 exactly when some pending source has a nonzero priority for processor k and type 0 (type 1). A masked source never drives either line.
- R6: prio_o[2k+1:2k] equals the largest priority among the pending sources that reach processor k, or 0 if there are none.
- R7: The control register and every routing register have a set alias at +4, where written 1s set bits, and a clear alias at +8, where written 1s clear bits.
- R8: A non-secure write leaves unchanged any routing nibble whose trust bit is 1. The other nibbles of the same register still update.
- R9: A source is secured when any of its four trust bits is 1. A non-secure read of the pending register returns 0 in the bit of every secured source.
- R10: A non-secure write to the clear register has no effect on secured sources.
- R11: While control bit 7 (clock gate) is 1, no new pending bits are latched, and only sources with priority 3 drive irq_o, fiq_o and prio_o.
- R12: The lock bit (control bit 5) can be changed only by secure writes. While it is 1, non-secure writes cannot change control bits 7 and 6.
- R13: Setting control bit 6 starts a soft reset. The bit reads 1 for exactly two cycles and then returns to 0 by itself, and all pending and routing state is 0 when it drops.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | NSRC | Interrupt request lines, sampled each rising edge |
| bus_en | input | 1 | Bus transaction valid this cycle |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_secure | input | 1 | Transaction comes from a secure master |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, registered, valid the cycle after a read |
| irq_o | output | NCPU | Normal interrupt line per processor |
| fiq_o | output | NCPU | Fast interrupt line per processor |
| prio_o | output | 2*NCPU | Highest active priority per processor |

## Verification
Every one of the 32 sources is set and cleared on its own, which separates the bit lanes and the address decode of the pending and clear registers. One source is then swept through all four processors, all four priority codes and both types, and the bench predicts irq_o, fiq_o and prio_o from the nibble value. This sweep catches errors in field position, priority decode and type selection. Mixed patterns with two sources at different priorities show whether the maximum, rather than the last source, drives prio_o. Paired secure and non-secure accesses, made with the lock, gate and soft reset each applied in turn, show whether every filter acts on the right bit.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

    localparam int NIB_W   = 4;
    localparam int PRIO_W  = 2;

    localparam int CB_GATE = 7;
    localparam int CB_SRST = 6;
    localparam int CB_LOCK = 5;

    typedef enum logic [1:0] {
        PR_MASKED = 2'd0,
        PR_LOW    = 2'd1,
        PR_HIGH   = 2'd2,
        PR_NMI    = 2'd3
    } prio_e;

    typedef enum logic [1:0] {
        WM_WRITE = 2'd0,
        WM_SET   = 2'd1,
        WM_CLR   = 2'd2,
        WM_NONE  = 2'd3
    } wmode_e;

    typedef struct packed {
        prio_e prio;
        logic  fast;
        logic  trust;
    } nib_t;

    typedef struct packed {
        logic gate;
        logic srst;
        logic lock;
    } ctrl_t;

    function automatic wmode_e wm_decode(input logic [3:0] off);
        case (off)
            4'h0:    return WM_WRITE;
            4'h4:    return WM_SET;
            4'h8:    return WM_CLR;
            default: return WM_NONE;
        endcase
    endfunction

    function automatic logic wm_bit(input logic cur, input logic wd, input wmode_e m);
        case (m)
            WM_WRITE: return wd;
            WM_SET:   return cur | wd;
            WM_CLR:   return cur & ~wd;
            default:  return cur;
        endcase
    endfunction

    function automatic logic [NIB_W-1:0] wm_nib(input logic [NIB_W-1:0] cur,
                                                input logic [NIB_W-1:0] wd,
                                                input wmode_e m);
        logic [NIB_W-1:0] r;
        for (int i = 0; i < NIB_W; i++) r[i] = wm_bit(cur[i], wd[i], m);
        return r;
    endfunction

endpackage

// File: rtl/sirq_ctrl.sv
module sirq_ctrl
    import sirq_pkg::*;
#(
    parameter int SR_CYCLES = 2
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   wr_en,
    input  logic   wr_sec,
    input  wmode_e wmode,
    input  ctrl_t  wdata,
    output logic   gate_o,
    output logic   srst_o,
    output logic   lock_o
);
    localparam int CNT_W = (SR_CYCLES > 1) ? $clog2(SR_CYCLES) : 1;

    logic             gate_q, srst_q, lock_q;
    logic [CNT_W-1:0] cnt_q;
    logic             prot_ok, lock_ok;
    ctrl_t            nx;

    assign prot_ok = wr_en && (wr_sec || !lock_q);
    assign lock_ok = wr_en && wr_sec;

    always_comb begin
        nx.gate = wm_bit(gate_q, wdata.gate, wmode);
        nx.srst = wm_bit(srst_q, wdata.srst, wmode);
        nx.lock = wm_bit(lock_q, wdata.lock, wmode);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gate_q <= 1'b0;
            srst_q <= 1'b0;
            lock_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            if (prot_ok) gate_q <= nx.gate;
            if (lock_ok) lock_q <= nx.lock;
            if (srst_q) begin
                if (cnt_q == CNT_W'(SR_CYCLES - 1)) begin
                    srst_q <= 1'b0;
                    cnt_q  <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end else if (prot_ok && nx.srst) begin
                srst_q <= 1'b1;
            end
        end
    end

    assign gate_o = gate_q;
    assign srst_o = srst_q;
    assign lock_o = lock_q;

    // R12: locked control bits ignore non-secure writes
    a_r12_gate_locked: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_sec && lock_q) |=> $stable(gate_q));
    // R12: lock itself only moves on secure writes
    a_r12_lock_secure_only: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_sec) |=> $stable(lock_q));
    // R13: soft reset stays up for more than one cycle
    a_r13_srst_holds: assert property (@(posedge clk) disable iff (rst)
        $rose(srst_q) |=> (srst_q || SR_CYCLES == 1));
    // R13: sequence counter never runs past its end
    a_r13_srst_bounded: assert property (@(posedge clk) disable iff (rst)
        (cnt_q != '0) |-> srst_q);

endmodule

// File: rtl/sirq_pending.sv
module sirq_pending #(
    parameter int NSRC = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            srst,
    input  logic            gate,
    input  logic [NSRC-1:0] src_i,
    input  logic [NSRC-1:0] clr_mask,
    output logic [NSRC-1:0] pend_o
);
    logic [NSRC-1:0] pend_q;

    always_ff @(posedge clk) begin
        if (rst || srst) pend_q <= '0;
        else             pend_q <= (pend_q & ~clr_mask) | (gate ? '0 : src_i);
    end

    assign pend_o = pend_q;

    // R2: pending bits persist when nothing clears them
    a_r2_pend_sticky: assert property (@(posedge clk) disable iff (rst)
        (!srst && clr_mask == '0) |=> ((pend_q & $past(pend_q)) == $past(pend_q)));
    // R11: gated block latches nothing new
    a_r11_gate_blocks: assert property (@(posedge clk) disable iff (rst)
        gate |=> ((pend_q & ~$past(pend_q)) == '0));
    // R13: soft reset empties the pending set
    a_r13_pend_wiped: assert property (@(posedge clk) disable iff (rst)
        srst |=> (pend_q == '0));

endmodule

// File: rtl/sirq_route_bank.sv
module sirq_route_bank
    import sirq_pkg::*;
#(
    parameter int NSRC   = 32,
    parameter int NCPU   = 4,
    parameter int SLOT_W = 8,
    localparam int RW    = NCPU * NIB_W
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      srst,
    input  logic                      wr_en,
    input  logic                      wr_sec,
    input  logic [SLOT_W-1:0]         wr_sel,
    input  wmode_e                    wmode,
    input  logic [RW-1:0]             wdata,
    output logic [NSRC-1:0][RW-1:0]   route_o
);
    for (genvar s = 0; s < NSRC; s++) begin : g_src
        for (genvar k = 0; k < NCPU; k++) begin : g_cpu
            logic [NIB_W-1:0] nib_q;
            logic             hit;

            assign hit = wr_en && (wr_sel == SLOT_W'(s)) && (wr_sec || !nib_q[0]);

            always_ff @(posedge clk) begin
                if (rst || srst) nib_q <= '0;
                else if (hit)    nib_q <= wm_nib(nib_q, wdata[k*NIB_W +: NIB_W], wmode);
            end

            assign route_o[s][k*NIB_W +: NIB_W] = nib_q;

            // R8: trusted nibble is frozen against non-secure writes
            a_r8_trust_guard: assert property (@(posedge clk) disable iff (rst)
                (wr_en && !wr_sec && !srst && nib_q[0]) |=> $stable(nib_q));
            // R13: soft reset clears routing
            a_r13_route_wiped: assert property (@(posedge clk) disable iff (rst)
                srst |=> (nib_q == '0));
        end
    end

endmodule

// File: rtl/sirq_route_eval.sv
module sirq_route_eval
    import sirq_pkg::*;
#(
    parameter int NSRC = 32,
    parameter int NCPU = 4,
    localparam int RW  = NCPU * NIB_W
) (
    input  logic [NSRC-1:0]          pend,
    input  logic                     gate,
    input  logic [NSRC-1:0][RW-1:0]  route,
    output logic [NSRC-1:0]          secured_o,
    output logic [NCPU-1:0]          irq_o,
    output logic [NCPU-1:0]          fiq_o,
    output logic [NCPU*PRIO_W-1:0]   prio_o
);
    for (genvar s = 0; s < NSRC; s++) begin : g_sec
        always_comb begin
            secured_o[s] = 1'b0;
            for (int k = 0; k < NCPU; k++) begin
                secured_o[s] = secured_o[s] | route[s][k*NIB_W];
            end
        end
    end

    for (genvar k = 0; k < NCPU; k++) begin : g_cpu
        logic [PRIO_W-1:0] best;
        always_comb begin
            nib_t n;
            logic elig;
            irq_o[k] = 1'b0;
            fiq_o[k] = 1'b0;
            best     = '0;
            for (int s = 0; s < NSRC; s++) begin
                n    = nib_t'(route[s][k*NIB_W +: NIB_W]);
                elig = pend[s] && (n.prio != PR_MASKED) && (!gate || n.prio == PR_NMI);
                if (elig) begin
                    if (n.fast) fiq_o[k] = 1'b1;
                    else        irq_o[k] = 1'b1;
                    if (n.prio > best) best = n.prio;
                end
            end
        end
        assign prio_o[k*PRIO_W +: PRIO_W] = best;
    end

endmodule

// File: rtl/sirq_router.sv
module sirq_router
    import sirq_pkg::*;
#(
    parameter int NSRC      = 32,
    parameter int NCPU      = 4,
    parameter int ADDR_W    = 12,
    parameter int DW        = 32,
    parameter int SR_CYCLES = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NSRC-1:0]          src_i,
    input  logic                     bus_en,
    input  logic                     bus_wr,
    input  logic                     bus_secure,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [DW-1:0]            bus_wdata,
    output logic [DW-1:0]            bus_rdata,
    output logic [NCPU-1:0]          irq_o,
    output logic [NCPU-1:0]          fiq_o,
    output logic [NCPU*PRIO_W-1:0]   prio_o
);
    localparam int RW      = NCPU * NIB_W;
    localparam int SLOT_W  = ADDR_W - 4;
    localparam int SIDX_W  = (NSRC > 1) ? $clog2(NSRC) : 1;
    localparam int SLOT_PD = 1;   // pending at 0x10, clear at 0x14
    localparam int SLOT_RT = 2;   // routing starts at 0x20

    logic                     wr, rd;
    logic [SLOT_W-1:0]        slot, route_sel;
    logic [3:0]               off;
    wmode_e                   wmode;
    logic                     hit_ctrl, hit_pend, hit_clr, hit_route;
    logic                     gate, srst, lock;
    ctrl_t                    ctrl_wd;
    logic [NSRC-1:0]          pend, secured, clr_mask;
    logic [NSRC-1:0][RW-1:0]  route;
    logic [DW-1:0]            rdata_d, rdata_q;

    assign wr        = bus_en && bus_wr;
    assign rd        = bus_en && !bus_wr;
    assign slot      = bus_addr[ADDR_W-1:4];
    assign off       = bus_addr[3:0];
    assign wmode     = wm_decode(off);
    assign route_sel = slot - SLOT_W'(SLOT_RT);
    assign hit_ctrl  = (slot == '0) && (wmode != WM_NONE);
    assign hit_pend  = (slot == SLOT_W'(SLOT_PD)) && (off == 4'h0);
    assign hit_clr   = (slot == SLOT_W'(SLOT_PD)) && (off == 4'h4);
    assign hit_route = (slot >= SLOT_W'(SLOT_RT)) && (route_sel < SLOT_W'(NSRC));

    assign ctrl_wd = '{gate: bus_wdata[CB_GATE], srst: bus_wdata[CB_SRST], lock: bus_wdata[CB_LOCK]};

    assign clr_mask = (wr && hit_clr)
                    ? (bus_wdata[NSRC-1:0] & (bus_secure ? {NSRC{1'b1}} : ~secured))
                    : '0;

    sirq_ctrl #(.SR_CYCLES(SR_CYCLES)) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr && hit_ctrl),
        .wr_sec (bus_secure),
        .wmode  (wmode),
        .wdata  (ctrl_wd),
        .gate_o (gate),
        .srst_o (srst),
        .lock_o (lock)
    );

    sirq_pending #(.NSRC(NSRC)) u_pend (
        .clk      (clk),
        .rst      (rst),
        .srst     (srst),
        .gate     (gate),
        .src_i    (src_i),
        .clr_mask (clr_mask),
        .pend_o   (pend)
    );

    sirq_route_bank #(.NSRC(NSRC), .NCPU(NCPU), .SLOT_W(SLOT_W)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .srst    (srst),
        .wr_en   (wr && hit_route && wmode != WM_NONE),
        .wr_sec  (bus_secure),
        .wr_sel  (route_sel),
        .wmode   (wmode),
        .wdata   (bus_wdata[RW-1:0]),
        .route_o (route)
    );

    sirq_route_eval #(.NSRC(NSRC), .NCPU(NCPU)) u_eval (
        .pend      (pend),
        .gate      (gate),
        .route     (route),
        .secured_o (secured),
        .irq_o     (irq_o),
        .fiq_o     (fiq_o),
        .prio_o    (prio_o)
    );

    always_comb begin
        rdata_d = '0;
        if (hit_ctrl) begin
            rdata_d[CB_GATE] = gate;
            rdata_d[CB_SRST] = srst;
            rdata_d[CB_LOCK] = lock;
        end else if (hit_pend) begin
            rdata_d = DW'(pend & (bus_secure ? {NSRC{1'b1}} : ~secured));
        end else if (hit_route) begin
            rdata_d = DW'(route[route_sel[SIDX_W-1:0]]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)     rdata_q <= '0;
        else if (rd) rdata_q <= rdata_d;
    end

    assign bus_rdata = rdata_q;

    // R5: a line only rises with something pending
    a_r5_line_needs_pend: assert property (@(posedge clk) disable iff (rst)
        ((irq_o != '0) || (fiq_o != '0)) |-> (pend != '0));
    // R9: non-secure view hides secured sources
    a_r9_ns_read_masked: assert property (@(posedge clk) disable iff (rst)
        (rd && !bus_secure && hit_pend) |=> ((bus_rdata[NSRC-1:0] & $past(secured)) == '0));
    // R10: non-secure clear leaves secured sources pending
    a_r10_ns_clear_spared: assert property (@(posedge clk) disable iff (rst)
        (wr && !bus_secure && hit_clr && !srst) |=> (($past(pend) & $past(secured) & ~pend) == '0));

endmodule

// File: tb/sirq_router_tb_top.sv
module sirq_router_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NSRC = 32;
    localparam int NCPU = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NSRC-1:0]   src_i = '0;
    logic              bus_en = 1'b0, bus_wr = 1'b0, bus_secure = 1'b0;
    logic [11:0]       bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [NCPU-1:0]   irq_o, fiq_o;
    logic [2*NCPU-1:0] prio_o;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sirq_router dut_i (
        .clk(clk), .rst(rst), .src_i(src_i),
        .bus_en(bus_en), .bus_wr(bus_wr), .bus_secure(bus_secure),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .fiq_o(fiq_o), .prio_o(prio_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // all tasks start and end at a falling edge
    task automatic wr(input logic sec, input logic [11:0] a, input logic [31:0] d);
        bus_en = 1; bus_wr = 1; bus_secure = sec; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 0; bus_wr = 0;
    endtask

    task automatic rd(input logic sec, input logic [11:0] a, output logic [31:0] d);
        bus_en = 1; bus_wr = 0; bus_secure = sec; bus_addr = a;
        @(negedge clk);
        bus_en = 0;
        d = bus_rdata;
    endtask

    task automatic pulse(input logic [NSRC-1:0] m);
        src_i = m;
        @(negedge clk);
        src_i = '0;
    endtask

    function automatic logic [11:0] ra(input int n);
        return 12'(32'h20 + n * 16);
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst = 0;

        // R1 reset state
        check("R1 outputs", {8'h0, irq_o, fiq_o, prio_o}, 32'h0);
        rd(1, 12'h000, d); check("R1 ctrl", d, 0);
        rd(1, 12'h010, d); check("R1 pending", d, 0);
        rd(1, ra(0), d);   check("R1 route0", d, 0);
        rd(1, ra(31), d);  check("R1 route31", d, 0);

        // R2/R3 every source lane
        for (int n = 0; n < NSRC; n++) begin
            pulse(32'h1 << n);
            rd(1, 12'h010, d); check($sformatf("R2 latch src%0d", n), d, 32'h1 << n);
            wr(1, 12'h014, 32'h1 << n);
            rd(1, 12'h010, d); check($sformatf("R3 clear src%0d", n), d, 0);
        end

        // R2 persistence, R3 partial clear
        pulse(32'h3);
        repeat (3) @(negedge clk);
        rd(1, 12'h010, d); check("R2 sticky", d, 32'h3);
        wr(1, 12'h014, 32'h1);
        rd(1, 12'h010, d); check("R3 partial", d, 32'h2);
        wr(1, 12'h014, 32'h2);

        // R4/R5/R6 sweep of nibble fields on source 5
        for (int k = 0; k < NCPU; k++) begin
            for (int p = 0; p < 4; p++) begin
                for (int t = 0; t < 2; t++) begin
                    logic [31:0] v;
                    v = 32'(((p << 2) | (t << 1)) << (4 * k));
                    wr(1, ra(5), v);
                    rd(1, ra(5), d); check("R4 readback", d, v);
                    pulse(32'h20);
                    check("R5 irq", {28'h0, irq_o}, (p != 0 && t == 0) ? (32'h1 << k) : 0);
                    check("R5 fiq", {28'h0, fiq_o}, (p != 0 && t == 1) ? (32'h1 << k) : 0);
                    check("R6 prio", {24'h0, prio_o}, 32'(p << (2 * k)));
                    wr(1, 12'h014, 32'h20);
                    check("R5 idle", {24'h0, irq_o, fiq_o}, 0);
                end
            end
        end
        wr(1, ra(5), 0);

        // R6 highest of two sources on cpu2
        wr(1, ra(1), 32'h0400);
        wr(1, ra(2), 32'h0A00);
        pulse(32'h6);
        check("R6 max", {24'h0, prio_o}, 32'h20);
        check("R5 both irq", {28'h0, irq_o}, 32'h4);
        check("R5 both fiq", {28'h0, fiq_o}, 32'h4);
        wr(1, 12'h014, 32'h4);
        check("R6 after clear", {24'h0, prio_o}, 32'h10);
        check("R5 fiq gone", {28'h0, fiq_o}, 0);
        wr(1, 12'h014, 32'hFF);
        wr(1, ra(1), 0); wr(1, ra(2), 0);

        // R7 aliases
        wr(1, ra(3), 32'h0F0F);
        wr(1, ra(3) + 4, 32'h00F0);
        rd(1, ra(3), d); check("R7 route set", d, 32'h0FFF);
        wr(1, ra(3) + 8, 32'h0F00);
        rd(1, ra(3), d); check("R7 route clr", d, 32'h00FF);
        wr(1, ra(3), 0);
        wr(1, 12'h004, 32'h80);
        rd(1, 12'h000, d); check("R7 ctrl set", d, 32'h80);
        wr(1, 12'h008, 32'h80);
        rd(1, 12'h000, d); check("R7 ctrl clr", d, 0);

        // R8 trusted nibble
        wr(1, ra(7), 32'h0009);
        wr(0, ra(7), 32'h2222);
        rd(1, ra(7), d); check("R8 ns write", d, 32'h2229);
        wr(0, ra(7) + 8, 32'h000F);
        rd(1, ra(7), d); check("R8 ns clr trusted", d, 32'h2229);
        wr(0, ra(7) + 8, 32'h00F0);
        rd(1, ra(7), d); check("R8 ns clr open", d, 32'h2209);
        wr(1, ra(7), 0);

        // R9/R10 secured source 7 (trust on cpu1 only)
        wr(1, ra(7), 32'h0010);
        pulse(32'h81);
        rd(0, 12'h010, d); check("R9 ns view", d, 32'h01);
        rd(1, 12'h010, d); check("R9 s view", d, 32'h81);
        wr(0, 12'h014, 32'h81);
        rd(1, 12'h010, d); check("R10 ns clear", d, 32'h80);
        wr(1, 12'h014, 32'h80);
        rd(1, 12'h010, d); check("R10 s clear", d, 0);
        wr(1, ra(7), 0);

        // R11 clock gate
        wr(1, ra(4), 32'h000C);
        wr(1, ra(6), 32'h0004);
        pulse(32'h50);
        check("R11 ungated prio", {24'h0, prio_o}, 32'h3);
        wr(1, 12'h004, 32'h80);
        check("R11 nmi passes", {28'h0, irq_o}, 32'h1);
        check("R11 nmi prio", {24'h0, prio_o}, 32'h3);
        wr(1, 12'h014, 32'h10);
        check("R11 low held", {28'h0, irq_o}, 0);
        check("R11 low prio", {24'h0, prio_o}, 0);
        pulse(32'h8);
        rd(1, 12'h010, d); check("R11 no latch", d, 32'h40);
        wr(1, 12'h008, 32'h80);
        check("R11 ungate", {24'h0, prio_o}, 32'h1);
        wr(1, 12'h014, 32'hFF);
        wr(1, ra(4), 0); wr(1, ra(6), 0);

        // R12 lock
        wr(0, 12'h004, 32'h20);
        rd(1, 12'h000, d); check("R12 ns lock", d, 0);
        wr(1, 12'h004, 32'h20);
        rd(1, 12'h000, d); check("R12 s lock", d, 32'h20);
        wr(0, 12'h004, 32'hC0);
        rd(1, 12'h000, d); check("R12 ns locked", d, 32'h20);
        wr(0, 12'h000, 32'h00);
        rd(1, 12'h000, d); check("R12 ns unlock", d, 32'h20);
        wr(1, 12'h004, 32'h80);
        rd(1, 12'h000, d); check("R12 s gate", d, 32'hA0);
        wr(1, 12'h008, 32'hA0);
        wr(0, 12'h004, 32'h80);
        rd(1, 12'h000, d); check("R12 ns open", d, 32'h80);
        wr(0, 12'h008, 32'h80);

        // R13 soft reset
        wr(1, ra(9), 32'h1234);
        pulse(32'h200);
        wr(1, 12'h004, 32'h40);
        rd(1, 12'h000, d); check("R13 first", d, 32'h40);
        rd(1, 12'h000, d); check("R13 second", d, 32'h40);
        rd(1, 12'h000, d); check("R13 dropped", d, 0);
        rd(1, 12'h010, d); check("R13 pend wiped", d, 0);
        rd(1, ra(9), d);   check("R13 route wiped", d, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule